// File: doc/BRIEF.md
# PLL Digital Lock Monitor

This block watches the divided reference and the divided feedback streams that feed a phase detector, and it raises an active-high lock flag once the loop is settled. Each input passes through a two-flop synchronizer into the free-running measurement clock domain. A rising-edge detector follows each synchronizer. The phase error of a comparison cycle is the number of measurement-clock periods between the rising edge of one stream and the matching rising edge of the other. Either stream may lead.

Two thresholds, expressed in picoseconds and converted to counts through the clock-period parameter, sort every measured cycle into good, marginal or bad. A run of consecutive good cycles declares lock, and the required run length depends on a static precision input. A single bad cycle drops lock at once. A marginal cycle restarts the run but leaves an existing lock in place. If a leading edge finds no partner within a timeout window, the cycle is treated as bad.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset the lock output is low and the good-run counter is zero, so a full run of good cycles is needed before lock, whatever happened before reset.
- R2: The error of a cycle is the count of measurement-clock periods between the two synchronized rising edges. It is measured the same way whichever stream leads.
- R3: With `precise` low, lock rises on the third consecutive good cycle and not before. A good cycle has an error below the acquire limit, which is 5 counts or fewer at the default parameters.
- R4: With `precise` high, lock rises on the fifth consecutive good cycle and not before.
- R5: A bad cycle clears lock in the cycle it completes and restarts the run. A bad cycle has an error above the lose limit, which is 11 counts or more at the default parameters.
- R6: A marginal cycle, with an error of 6 to 10 counts at the default parameters, restarts the run but leaves an asserted lock high.
- R7: If no matching edge of the other stream arrives within 32 measurement clocks of a leading edge, the cycle counts as bad.
- R8: Edges that arrive in the same cycle give an error of zero, which is good. While good cycles continue, lock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference stream, asynchronous |
| fb_div | input | 1 | Divided feedback stream, asynchronous |
| precise | input | 1 | Run-length select: 0 needs 3 good cycles, 1 needs 5 |
| locked | output | 1 | Active-high lock flag |

## Verification
In a single clock edge, one comparison cycle can complete and the lock decision it triggers can be taken. The sharpest case is two edges that coincide: they open and close a measurement in the same cycle, and that same cycle can also push the run to the required length. The bench provokes this by driving both streams high on one clock edge as the last good cycle of a run. It expects lock to be high immediately after that cycle and low one cycle earlier in the sequence. It judges the result against a reference model of the run counter and lock flag.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int CLK_PS     = 2500,
  parameter int ACQ_PS     = 15000,
  parameter int LOSE_PS    = 25000,
  parameter int TMO_CNT    = 32,
  parameter int RUN_LOOSE  = 3,
  parameter int RUN_STRICT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_div,
  input  logic fb_div,
  input  logic precise,
  output logic locked
);
  localparam int ACQ_LIM  = (ACQ_PS + CLK_PS - 1) / CLK_PS;
  localparam int LOSE_LIM = LOSE_PS / CLK_PS;
  localparam int CW       = $clog2(TMO_CNT + 1);
  localparam int RW       = $clog2(RUN_STRICT + 1);
  localparam logic [CW-1:0] ACQ_L  = CW'(ACQ_LIM);
  localparam logic [CW-1:0] LOSE_L = CW'(LOSE_LIM);
  localparam logic [CW-1:0] TMO_L  = CW'(TMO_CNT);
  localparam logic [RW-1:0] RUN_MAX = RW'(RUN_STRICT);

  logic [2:0]    ref_sh, fb_sh;
  logic          ref_rise, fb_rise;
  logic          waiting, lead_ref;
  logic [CW-1:0] cnt, err;
  logic          done, tmo, partner;
  logic          res_good, res_mid, res_bad;
  logic [RW-1:0] run, need;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_sh <= '0;
      fb_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_div};
      fb_sh  <= {fb_sh[1:0], fb_div};
    end

  assign ref_rise = ref_sh[1] & ~ref_sh[2];
  assign fb_rise  = fb_sh[1] & ~fb_sh[2];
  assign partner  = lead_ref ? fb_rise : ref_rise;

  always_comb begin
    done = 1'b0;
    tmo  = 1'b0;
    err  = '0;
    if (!waiting) begin
      done = ref_rise & fb_rise;
    end else if (partner) begin
      done = 1'b1;
      err  = cnt;
    end else if (cnt == TMO_L) begin
      done = 1'b1;
      tmo  = 1'b1;
    end
  end

  assign res_good = done && !tmo && (err < ACQ_L);
  assign res_bad  = done && (tmo || (err > LOSE_L));
  assign res_mid  = done && !res_good && !res_bad;
  assign need     = precise ? RW'(RUN_STRICT) : RW'(RUN_LOOSE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      waiting  <= 1'b0;
      lead_ref <= 1'b0;
      cnt      <= '0;
    end else if (!waiting) begin
      if (ref_rise ^ fb_rise) begin
        waiting  <= 1'b1;
        lead_ref <= ref_rise;
        cnt      <= CW'(1);
      end
    end else if (done) begin
      waiting <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (res_good) begin
      if (run != RUN_MAX) run <= run + 1'b1;
      if (({1'b0, run} + 1'b1) >= {1'b0, need}) locked <= 1'b1;
    end else if (res_mid) begin
      run <= '0;
    end else if (res_bad) begin
      run    <= '0;
      locked <= 1'b0;
    end

  // R5
  bad_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_bad |=> !locked);
  // R6
  mid_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && res_mid) |=> locked);
  // R6
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mid || res_bad) |=> (run == '0));
  // R3
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(res_good) && (run >= need)));
  // R7
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (cnt <= TMO_L));
  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !res_bad) |=> locked);
endmodule

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GOOD_MAX = 5;
  localparam int BAD_MIN  = 11;
  localparam int TMO      = 32;

  logic clk = 1'b0, rst_n = 1'b0, ref_div = 1'b0, fb_div = 1'b0, precise = 1'b0;
  logic locked;
  int checks = 0, fails = 0;
  int m_run = 0;
  bit m_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_monitor dut_i (.clk(clk), .rst_n(rst_n), .ref_div(ref_div),
                          .fb_div(fb_div), .precise(precise), .locked(locked));

  function automatic int classify(int d);
    if (d <= GOOD_MAX) return 0;
    if (d < BAD_MIN) return 1;
    return 2;
  endfunction

  function automatic void model_step(int cls);
    int need;
    need = precise ? 5 : 3;
    if (cls == 0) begin
      if (m_run < 5) m_run++;
      if (m_run >= need) m_lock = 1;
    end else begin
      m_run = 0;
      if (cls == 2) m_lock = 0;
    end
  endfunction

  task automatic check(string tag);
    checks++;
    if (locked !== m_lock) begin
      fails++;
      $display("FAIL %s: locked=%b expected=%b", tag, locked, m_lock);
    end
  endtask

  task automatic do_reset(bit p);
    @(negedge clk);
    rst_n = 1'b0; ref_div = 1'b0; fb_div = 1'b0; precise = p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    m_run = 0; m_lock = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
  endtask

  task automatic cmp_cycle(int d, bit ref_first, string tag);
    int cls;
    @(negedge clk);
    if (d == 0) begin ref_div = 1'b1; fb_div = 1'b1; end
    else if (ref_first) ref_div = 1'b1;
    else fb_div = 1'b1;
    repeat (d) @(negedge clk);
    ref_div = 1'b1; fb_div = 1'b1;
    repeat (4) @(negedge clk);
    ref_div = 1'b0; fb_div = 1'b0;
    repeat (8) @(negedge clk);
    cls = classify(d);
    model_step(cls);
    check(tag);
  endtask

  task automatic timeout_cycle();
    @(negedge clk);
    ref_div = 1'b1;
    repeat (TMO + 6) @(negedge clk);
    ref_div = 1'b0;
    repeat (8) @(negedge clk);
    model_step(2);
    check("R7 timeout");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: locked=%b expected=finished", locked);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset(1'b0);
    cmp_cycle(1, 1, "R3 run1");
    cmp_cycle(2, 0, "R3 run2");
    do_reset(1'b0);
    cmp_cycle(3, 1, "R1 run cleared");
    cmp_cycle(4, 1, "R1 run cleared");
    cmp_cycle(0, 1, "R8 coincident completes run");
    cmp_cycle(GOOD_MAX, 0, "R8 hold");
    cmp_cycle(6, 1, "R6 mid keeps lock");
    cmp_cycle(10, 0, "R6 mid upper edge");
    cmp_cycle(BAD_MIN, 1, "R5 bad clears");
    cmp_cycle(2, 0, "R2 fb leads");
    cmp_cycle(2, 1, "R2 ref leads");
    cmp_cycle(GOOD_MAX, 1, "R3 third good");
    timeout_cycle();
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) cmp_cycle(i, i[0], "R4 not yet");
    cmp_cycle(5, 0, "R4 fifth good");
    cmp_cycle(14, 1, "R5 bad strict");
    for (int ph = 0; ph < 12; ph++) begin
      do_reset(1'(($urandom % 2)));
      for (int k = 0; k < 25; k++) begin
        int r, d;
        string tg;
        r = $urandom % 100;
        if (r < 3) begin
          timeout_cycle();
        end else begin
          if (r < 80) d = $urandom % 6;
          else if (r < 92) d = 6 + $urandom % 5;
          else d = 11 + $urandom % 4;
          case (classify(d))
            0: tg = (d == 0) ? "R8 random" : (precise ? "R4 random" : "R3 random");
            1: tg = "R6 random";
            default: tg = "R5 random";
          endcase
          cmp_cycle(d, 1'($urandom % 2), tg);
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule